// File: doc/BRIEF.md
# Frame-synchronised serial word link

This block moves 8-bit words between two parts of a chip that share one clock, over three wires: the common clock, a serial data line and a one-cycle word-start strobe. The transmit half accepts a parallel word through a valid/ready handshake. It then shifts the word out one bit per clock, raising the start strobe during the first bit only. The receive half locks onto that strobe, gathers eight bits and hands the assembled word to its user together with a single-cycle valid pulse.

The transmit half launches both serial lines from falling-edge flops. The receive half samples them on the rising edge, which leaves half a clock period of margin on each side of the sampling instant. Words may follow each other with no gap, or be separated by any number of idle cycles. The serial outputs and the receive inputs are separate ports. The lines can be looped back or run between two instances, and the receiver can be driven directly.

Top module: `fsync_word_link`

## Requirements
- R1: A word is serialised one bit per clock cycle, most significant bit first, so that eight consecutive cycles carry bits 7 down to 0.
- R2: The start strobe `ser_frame_o` is high during the cycle that carries bit 7 and low during the seven cycles that carry bits 6 to 0.
- R3: `ser_data_o` and `ser_frame_o` change only on the falling clock edge; they hold their value across the rising edge.
- R4: The receiver captures `ser_data_i` and `ser_frame_i` on the rising clock edge, so inputs that change at falling edges are received correctly.
- R5: A word is taken on a rising edge where `tx_valid` and `tx_ready` are both high. Its first bit and the start strobe appear at the next falling edge, and `tx_ready` is low during bits 7 to 1.
- R6: `tx_ready` is high while the last bit of a word is on the line, so a word offered at once goes out directly after, with its start strobe exactly eight cycles after the previous one.
- R7: With no word in progress, the transmitter holds `ser_frame_o` low and `ser_data_o` low.
- R8: On the rising edge that captures the eighth bit, the receiver raises `rx_valid` for exactly one cycle with the word on `rx_data`. This is eight cycles after the accepting edge in loopback. `rx_data` keeps that word until the next one completes.
- R9: A start strobe that arrives before a word is complete, including in the eighth bit position, discards the partial word and starts a new one at that bit. No `rx_valid` is raised for the discarded word.
- R10: Asserting `rst_n` clears both bit counters at once, forces `ser_frame_o`, `ser_data_o` and `rx_valid` low and makes `tx_ready` high. A word interrupted by reset is never delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_data | input | 8 | Parallel word to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can take a word on this rising edge |
| ser_data_o | output | 1 | Serial data out, launched on the falling edge |
| ser_frame_o | output | 1 | Word-start strobe out, launched on the falling edge |
| ser_data_i | input | 1 | Serial data into the receiver |
| ser_frame_i | input | 1 | Word-start strobe into the receiver |
| rx_data | output | 8 | Last word received |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new word |

## Verification
The properties presume that `tx_valid` and `tx_data` change only between rising edges and stay put until a word is taken. They also presume that the receive inputs change only at falling edges, as a copy of this transmitter would drive them. The bench drives every input on the falling edge and holds an offered word until `tx_ready` is seen high. For the restart cases it drives the receive lines directly with the same falling-edge timing. Outputs are read a falling edge or one nanosecond after the edge that moves them, never at that edge.

// File: rtl/link_pkg.sv
package link_pkg;

  // Transmit sequencer state
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

endpackage

// File: rtl/link_rst_sync.sv
// Asynchronous assert, synchronous release of the block-level reset.
module link_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/link_tx.sv
// Serialiser: word taken on the rising edge, each bit relaunched on the falling edge.
module link_tx
  import link_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              sdata_o,
  output logic              sframe_o
);

  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  tx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic              first_q, first_d;
  logic              accept;
  logic              adv_en;

  assign ready_o = (state_q == TX_IDLE) || (cnt_q == LAST);
  assign accept  = valid_i && ready_o;
  assign adv_en  = accept || (state_q == TX_SEND);

  // Next-state logic; cnt_q is the index of the bit now presented
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    first_d = 1'b0;
    if (accept) begin
      state_d = TX_SEND;
      cnt_d   = '0;
      shreg_d = word_i;
      first_d = 1'b1;
    end else if (state_q == TX_SEND) begin
      if (cnt_q == LAST) begin
        state_d = TX_IDLE;
        cnt_d   = '0;
        shreg_d = '0;
      end else begin
        cnt_d   = cnt_q + CW'(1);
        shreg_d = {shreg_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  // Rising-edge sequencer registers, advanced under adv_en
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      first_q <= 1'b0;
    end else begin
      first_q <= first_d;
      if (adv_en) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
        shreg_q <= shreg_d;
      end
    end
  end

  // Falling-edge launch stage: half a period before the far-end capture
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_o  <= 1'b0;
      sframe_o <= 1'b0;
    end else begin
      sdata_o  <= shreg_q[WORD_W-1];
      sframe_o <= first_q;
    end
  end

endmodule

// File: rtl/link_rx.sv
// Deserialiser: captures on the rising edge, word start taken from the frame strobe.
module link_rx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata_i,
  input  logic              sframe_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);

  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic              active_q, active_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;
  logic              cap_en;
  logic              word_ld;

  assign cap_en = sframe_i || active_q;

  // cnt_q counts the bits already captured in the current word
  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    word_d   = word_q;
    word_ld  = 1'b0;
    valid_d  = 1'b0;
    if (sframe_i) begin
      active_d = 1'b1;
      cnt_d    = CW'(1);
      shreg_d  = {{(WORD_W-1){1'b0}}, sdata_i};
    end else if (active_q) begin
      shreg_d = {shreg_q[WORD_W-2:0], sdata_i};
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        cnt_d    = '0;
        word_d   = shreg_d;
        word_ld  = 1'b1;
        valid_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      word_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (cap_en) begin
        active_q <= active_d;
        cnt_q    <= cnt_d;
        shreg_q  <= shreg_d;
      end
      if (word_ld) begin
        word_q <= word_d;
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/fsync_word_link.sv
module fsync_word_link #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              ser_data_o,
  output logic              ser_frame_o,
  input  logic              ser_data_i,
  input  logic              ser_frame_i,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  logic blk_rst_n;

  link_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (blk_rst_n)
  );

  link_tx #(.WORD_W(WORD_W)) u_tx (
    .clk      (clk),
    .rst_n    (blk_rst_n),
    .word_i   (tx_data),
    .valid_i  (tx_valid),
    .ready_o  (tx_ready),
    .sdata_o  (ser_data_o),
    .sframe_o (ser_frame_o)
  );

  link_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (blk_rst_n),
    .sdata_i  (ser_data_i),
    .sframe_i (ser_frame_i),
    .word_o   (rx_data),
    .valid_o  (rx_valid)
  );

endmodule

// File: rtl/link_chk.sv
module link_chk (
  input logic clk,
  input logic srst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic ser_frame_o,
  input logic ser_frame_i,
  input logic rx_valid
);

  // R2: start strobe lasts a single cycle
  a_r2_frame_one_cycle: assert property (@(posedge clk) disable iff (!srst_n)
    ser_frame_o |=> !ser_frame_o);

  // R5: a taken word shows its start strobe by the next rising edge
  a_r5_frame_after_take: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid && tx_ready) |=> ser_frame_o);

  // R5: no second word is taken while bit 7 is on the line
  a_r5_busy_after_take: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R8: word-valid is a single-cycle pulse
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    rx_valid |=> !rx_valid);

  // R9: a start strobe never completes a word on the following edge
  a_r9_restart_no_valid: assert property (@(posedge clk) disable iff (!srst_n)
    ser_frame_i |=> !rx_valid);

endmodule

bind fsync_word_link link_chk u_chk (
  .clk         (clk),
  .srst_n      (blk_rst_n),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .ser_frame_o (ser_frame_o),
  .ser_frame_i (ser_frame_i),
  .rx_valid    (rx_valid)
);

// File: tb/sim_fsync_word_link.sv
`timescale 1ns/1ps
module sim_fsync_word_link;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic       ser_data_o, ser_frame_o;
  logic       rx_d, rx_f;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       lb;
  logic       drv_d, drv_f;
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  assign rx_d = lb ? ser_data_o  : drv_d;
  assign rx_f = lb ? ser_frame_o : drv_f;

  fsync_word_link u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .ser_data_o  (ser_data_o),
    .ser_frame_o (ser_frame_o),
    .ser_data_i  (rx_d),
    .ser_frame_i (rx_f),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic lf [0:4095];
  logic ld [0:4095];
  logic [7:0] rx_q [$];
  int         rc_q [$];

  // Serial line log, sampled at rising edges (lines move on falling edges)
  always @(posedge clk) begin
    if (cyc < 4096) begin
      lf[cyc] = ser_frame_o;
      ld[cyc] = ser_data_o;
    end
    cyc = cyc + 1;
  end

  // Received words, sampled at falling edges; index is the rising edge that set them
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rx_valid === 1'b1) begin
      rx_q.push_back(rx_data);
      rc_q.push_back(cyc - 1);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // Offer a word at a falling edge; a = index of the accepting rising edge
  task automatic push(input logic [7:0] b, output int a);
    tx_data  = b;
    tx_valid = 1'b1;
    while (tx_ready !== 1'b1) @(negedge clk);
    a = cyc;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // R1/R2: line contents on the eight rising edges after acceptance
  task automatic check_word(input int a, input logic [7:0] b);
    logic [7:0] ab, af;
    for (int i = 1; i <= 8; i++) begin
      ab[8-i] = ld[a+i];
      af[8-i] = lf[a+i];
    end
    chk(ab === b, "R1 serial bits msb first", int'(ab), int'(b));
    chk(af === 8'h80, "R2 frame on first bit only", int'(af), 8'h80);
  endtask

  task automatic drive(input logic f, input logic d);
    drv_f = f;
    drv_d = d;
    @(negedge clk);
  endtask

  task automatic drive_word(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) drive(i == 0, b[7-i]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = 8'h00;
    lb = 1'b1; drv_d = 1'b0; drv_f = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_ready === 1'b1, "R10 ready in reset", int'(tx_ready), 1);
    chk({ser_frame_o, ser_data_o} === 2'b00, "R10 lines low in reset",
        int'({ser_frame_o, ser_data_o}), 0);
    chk(rx_valid === 1'b0, "R10 valid low in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_single();
    int a;
    rx_q.delete(); rc_q.delete();
    tx_data = 8'hA5; tx_valid = 1'b1;
    a = cyc;
    @(posedge clk); #1;
    chk(ser_frame_o === 1'b0, "R3 frame still low after rising edge", int'(ser_frame_o), 0);
    @(negedge clk); #1;
    chk(ser_frame_o === 1'b1, "R3 frame high after falling edge", int'(ser_frame_o), 1);
    chk(tx_ready === 1'b0, "R5 ready low during first bit", int'(tx_ready), 0);
    tx_valid = 1'b0;
    repeat (12) @(negedge clk);
    check_word(a, 8'hA5);
    chk(rx_q.size() == 1, "R8 one valid pulse", rx_q.size(), 1);
    chk(rx_q.size() > 0 && rx_q[0] == 8'hA5, "R8 received word",
        rx_q.size() > 0 ? int'(rx_q[0]) : -1, 8'hA5);
    chk(rc_q.size() > 0 && rc_q[0] == a + 8, "R8 valid eight cycles after take",
        rc_q.size() > 0 ? rc_q[0] - a : -1, 8);
    chk(rx_data === 8'hA5 && rx_valid === 1'b0, "R8 word held after pulse",
        int'(rx_data), 8'hA5);
  endtask

  task automatic t_b2b();
    logic [7:0] w [4];
    int a [4];
    int bad;
    w[0] = 8'h3C; w[1] = 8'hFF; w[2] = 8'h00; w[3] = 8'h81;
    rx_q.delete(); rc_q.delete();
    @(negedge clk);
    for (int k = 0; k < 4; k++) push(w[k], a[k]);
    for (int k = 1; k < 4; k++)
      chk(a[k] - a[k-1] == 8, "R6 back-to-back spacing", a[k] - a[k-1], 8);
    repeat (20) @(negedge clk);
    for (int k = 0; k < 4; k++) check_word(a[k], w[k]);
    chk(rx_q.size() == 4, "R6 four words received", rx_q.size(), 4);
    for (int k = 0; k < 4; k++) begin
      if (k < rx_q.size()) begin
        chk(rx_q[k] == w[k], "R6 word order", int'(rx_q[k]), int'(w[k]));
        chk(rc_q[k] == a[k] + 8, "R8 valid timing", rc_q[k] - a[k], 8);
      end
    end
    bad = 0;
    for (int i = a[3] + 9; i <= a[3] + 18; i++)
      if (lf[i] !== 1'b0 || ld[i] !== 1'b0) bad++;
    chk(bad == 0, "R7 idle lines low", bad, 0);
  endtask

  task automatic t_midword();
    lb = 1'b0;
    rx_q.delete(); rc_q.delete();
    @(negedge clk);
    drive_word(8'hF0, 4);
    drive_word(8'h96, 8);
    repeat (4) drive(1'b0, 1'b0);
    chk(rx_q.size() == 1, "R9 partial word dropped", rx_q.size(), 1);
    chk(rx_q.size() > 0 && rx_q[0] == 8'h96, "R4 falling-edge driven word captured",
        rx_q.size() > 0 ? int'(rx_q[0]) : -1, 8'h96);
    rx_q.delete(); rc_q.delete();
    drive_word(8'h11, 7);
    drive_word(8'h3E, 8);
    repeat (4) drive(1'b0, 1'b0);
    chk(rx_q.size() == 1, "R9 restart at eighth bit", rx_q.size(), 1);
    chk(rx_q.size() > 0 && rx_q[0] == 8'h3E, "R9 restarted word",
        rx_q.size() > 0 ? int'(rx_q[0]) : -1, 8'h3E);
    chk(rx_data === 8'h3E && rx_valid === 1'b0, "R8 word held while idle",
        int'(rx_data), 8'h3E);
    lb = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_mid();
    int a;
    rx_q.delete(); rc_q.delete();
    push(8'hC3, a);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({ser_frame_o, ser_data_o, rx_valid} === 3'b000, "R10 outputs cleared at once",
        int'({ser_frame_o, ser_data_o, rx_valid}), 0);
    chk(tx_ready === 1'b1, "R10 ready after reset", int'(tx_ready), 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (15) @(negedge clk);
    chk(rx_q.size() == 0, "R10 interrupted word not delivered", rx_q.size(), 0);
    push(8'h5A, a);
    repeat (12) @(negedge clk);
    check_word(a, 8'h5A);
    chk(rx_q.size() == 1 && rx_q[0] == 8'h5A, "R10 link works after reset",
        rx_q.size() > 0 ? int'(rx_q[0]) : -1, 8'h5A);
  endtask

  initial begin
    t_reset();
    t_single();
    t_b2b();
    t_midword();
    t_reset_mid();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule